// File: doc/BRIEF.md
# Packed-Word Serial Receive FIFO

This block sits behind a serial receiver and turns its stream of 8-bit characters into 32-bit words for a host. Characters are packed in arrival order, least significant byte first, into a word accumulator. A finished word goes into an eight-entry word queue. A word is finished when it holds four bytes, or earlier when a buffer-close pulse arrives. Each queued word carries a 2-bit count of its valid bytes and a marker that says whether a close ended it.

The host reaches the block through a small register port with two addresses: a status register and a data register. The host reads status first. Status reports whether a word can be taken, how many bytes of the head word are valid, a sticky closed flag and a sticky overrun flag. The host then reads the data register, which hands over the whole head word and pops it. The closed flag stalls further data reads until software writes 1 to its bit, so software can collect end-of-buffer state before the next buffer's data.

Top module: `packed_rx_fifo`

## Requirements
- R1: Characters are packed little-endian. The first byte of a word lands in bits [7:0] and the fourth in bits [31:24]. When the fourth byte is accepted, the word is queued with count code 00.
- R2: A read of the data register (reg_addr=1) while ready returns the head word and removes exactly that one entry. Words come out in the order they were queued.
- R3: Status bit 0 (ready) is 1 exactly when the queue holds at least one word and the closed flag is clear.
- R4: Status bits [2:1] give the valid-byte code of the head word while ready, and 00 otherwise. The codes are 00=4 bytes, 01=1, 10=2 and 11=3. Unused status bits read 0.
- R5: A close pulse while bytes are pending queues the partial word with its count. Closed (status bit 3) is then set in the cycle that word is popped. A character arriving in the same cycle as the close is included in that word. A close pulse with no pending bytes sets closed directly.
- R6: While closed is set, a data read returns 0 and pops nothing. Writing status with bit 3 = 1 clears closed, and writing 0 there leaves it set.
- R7: A character that arrives while the queue holds 8 words is dropped and sets sticky overrun (status bit 4). Writing status with bit 4 = 1 clears overrun.
- R8: A data read while the queue is empty returns 0 and leaves the queue unchanged.
- R9: After synchronous reset, status reads 0 and no word is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | One-cycle strobe for a received character |
| char_data | input | 8 | Received character |
| buf_close | input | 1 | One-cycle pulse that closes the current receive buffer |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status register, 1 = data register |
| reg_wdata | input | 32 | Write data (status write-1-to-clear bits) |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd, 0 otherwise |

## Verification
The bench fills the queue to eight words and sends four more characters. A design that checked fullness a cycle late would corrupt or overwrite the head instead of dropping those characters and flagging overrun. Partial words of one, two and three bytes check the byte-count encoding. A design that miscounted would report 00 for a three-byte word or shift bytes into the wrong lanes. A close with nothing pending must raise closed at once and then refuse reads without popping. A design that popped on a blocked read would lose the queued word, which the bench reads back after the acknowledge. A close in the same cycle as a character checks that the character joins the flushed word and is not lost or held for the next buffer.

// File: rtl/pkrx_pkg.sv
package pkrx_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int CNT_W   = $clog2(LANES);

    // status register bit positions
    localparam int ST_READY  = 0;
    localparam int ST_CODE_L = 1;
    localparam int ST_CLOSED = 3;
    localparam int ST_OVR    = 4;

    typedef logic [CNT_W-1:0] code_t;

    typedef struct packed {
        logic              tag;   // word ended by a buffer close
        code_t             code;  // valid bytes, 0 means all lanes
        logic [WORD_W-1:0] data;
    } entry_t;

    // byte count (1..LANES) to code: LANES wraps to zero
    function automatic code_t count_to_code(input logic [CNT_W:0] n);
        return n[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/pkrx_packer.sv
module pkrx_packer
    import pkrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              char_valid,
    input  logic [BYTE_W-1:0] char_data,
    input  logic              close_in,
    input  logic              full,
    output logic              push,
    output entry_t            push_entry,
    output logic              drop,
    output logic              close_now
);
    logic [WORD_W-1:0] acc_q, merged;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W:0]    cnt_n;
    logic              take;

    always_comb begin
        take   = char_valid & ~full;
        drop   = char_valid & full;
        merged = acc_q;
        if (take) merged[{cnt_q, 3'b000} +: BYTE_W] = char_data;
        cnt_n  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, take};
        push   = (cnt_n == (CNT_W+1)'(LANES)) | (close_in & (cnt_n != '0));
        close_now = close_in & (cnt_n == '0);
        push_entry.tag  = close_in;
        push_entry.code = count_to_code(cnt_n);
        push_entry.data = merged;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (push) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            acc_q <= merged;
            cnt_q <= cnt_n[CNT_W-1:0];
        end
    end

    // R7
    full_idle_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> (cnt_q == '0));
endmodule

// File: rtl/pkrx_fifo.sv
module pkrx_fifo
    import pkrx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  entry_t  push_entry,
    input  logic    pop,
    output entry_t  head,
    output logic    empty,
    output logic    full,
    output logic [AW:0] count
);
    entry_t        mem [DEPTH];
    logic [AW:0]   wp_q, rp_q;

    assign count = wp_q - rp_q;
    assign empty = (count == '0);
    assign full  = (count == (AW+1)'(DEPTH));
    assign head  = mem[rp_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push) begin
                mem[wp_q[AW-1:0]] <= push_entry;
                wp_q <= wp_q + 1'b1;
            end
            if (pop) rp_q <= rp_q + 1'b1;
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(push && full));
    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(pop && empty));
    // R2
    single_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/packed_rx_fifo.sv
module packed_rx_fifo
    import pkrx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        char_valid,
    input  logic [7:0]  char_data,
    input  logic        buf_close,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    localparam int AW = $clog2(DEPTH);

    logic        push, drop, close_now, pop, empty, full, ready;
    entry_t      push_entry, head;
    logic [AW:0] count;
    logic        closed_q, ovr_q, set_closed, clr_closed, clr_ovr, data_rd;
    logic [WORD_W-1:0] status;

    pkrx_packer u_pack (
        .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
        .close_in(buf_close), .full(full), .push(push), .push_entry(push_entry),
        .drop(drop), .close_now(close_now)
    );

    pkrx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_entry(push_entry), .pop(pop),
        .head(head), .empty(empty), .full(full), .count(count)
    );

    always_comb begin
        ready      = ~empty & ~closed_q;
        data_rd    = reg_rd & reg_addr;
        pop        = data_rd & ready;
        set_closed = close_now | (pop & head.tag);
        clr_closed = reg_wr & ~reg_addr & reg_wdata[ST_CLOSED];
        clr_ovr    = reg_wr & ~reg_addr & reg_wdata[ST_OVR];
        status     = '0;
        status[ST_READY]  = ready;
        status[ST_CODE_L +: CNT_W] = ready ? head.code : '0;
        status[ST_CLOSED] = closed_q;
        status[ST_OVR]    = ovr_q;
        if (!reg_rd)       reg_rdata = '0;
        else if (reg_addr) reg_rdata = ready ? head.data : '0;
        else               reg_rdata = status;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            closed_q <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            if (set_closed)      closed_q <= 1'b1;
            else if (clr_closed) closed_q <= 1'b0;
            if (drop)            ovr_q <= 1'b1;
            else if (clr_ovr)    ovr_q <= 1'b0;
        end
    end

    // R6
    closed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (closed_q && !clr_closed) |=> closed_q);
    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !clr_ovr) |=> ovr_q);
    // R8
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !ready && !push) |=> $stable(count));
endmodule

// File: tb/packed_rx_fifo_test.sv
module packed_rx_fifo_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        char_valid = 1'b0;
    logic [7:0]  char_data = '0;
    logic        buf_close = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    packed_rx_fifo uut (
        .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
        .buf_close(buf_close), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [2:0]  n;
        logic [31:0] word;
        logic [1:0]  code;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{3'd4, 32'h11223344, 2'b00},
        '{3'd1, 32'h000000AB, 2'b01},
        '{3'd2, 32'h0000C35A, 2'b10},
        '{3'd3, 32'h00030201, 2'b11}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic cl);
        @(negedge clk);
        char_valid = 1'b1; char_data = b; buf_close = cl;
        @(negedge clk);
        char_valid = 1'b0; buf_close = 1'b0;
    endtask

    task automatic close_pulse();
        @(negedge clk);
        buf_close = 1'b1;
        @(negedge clk);
        buf_close = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_status(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd(1'b0, d); check("R9 status after reset", d, 32'h0);
        // R8 empty data read
        rd(1'b1, d); check("R8 empty read data", d, 32'h0);
        rd(1'b0, d); check("R8 status after empty read", d, 32'h0);

        // table: R1 packing, R4 codes, R5 partial close
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < int'(VECS[i].n); k++) send(VECS[i].word[8*k +: 8], 1'b0);
            if (VECS[i].n != 3'd4) close_pulse();
            rd(1'b0, d); check("R4 status before read", d, {29'b0, VECS[i].code, 1'b1});
            rd(1'b1, d); check("R1 packed word", d, VECS[i].word);
            rd(1'b0, d);
            if (VECS[i].n != 3'd4) begin
                check("R5 closed after flushed word read", d, 32'h8);
                wr_status(32'h8);
                rd(1'b0, d); check("R6 closed cleared", d, 32'h0);
            end else begin
                check("R3 idle after read", d, 32'h0);
            end
        end

        // R5 direct close, R6 blocking and write-1-to-clear
        send(8'hA1, 1'b0); send(8'hA2, 1'b0); send(8'hA3, 1'b0); send(8'hA4, 1'b0);
        close_pulse();
        rd(1'b0, d); check("R5 direct close status", d, 32'h8);
        rd(1'b1, d); check("R6 blocked read returns zero", d, 32'h0);
        wr_status(32'h0);
        rd(1'b0, d); check("R6 write zero keeps closed", d, 32'h8);
        wr_status(32'h8);
        rd(1'b0, d); check("R3 ready after ack", d, 32'h1);
        rd(1'b1, d); check("R6 word survived blocked read", d, 32'hA4A3A2A1);
        rd(1'b0, d); check("R3 empty after read", d, 32'h0);

        // R5 character in same cycle as close
        send(8'h55, 1'b0); send(8'h66, 1'b0); send(8'h77, 1'b1);
        rd(1'b0, d); check("R5 same-cycle close status", d, 32'h7);
        rd(1'b1, d); check("R5 same-cycle close word", d, 32'h00776655);
        rd(1'b0, d); check("R5 closed after word", d, 32'h8);
        wr_status(32'h8);

        // R7 overrun; R2 ordering
        for (int c = 0; c < 36; c++) send(8'(c), 1'b0);
        rd(1'b0, d); check("R7 overrun status", d, 32'h11);
        for (int w = 0; w < 8; w++) begin
            rd(1'b1, d);
            check("R2 word order", d, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
        end
        rd(1'b0, d); check("R7 overrun sticky after drain", d, 32'h10);
        wr_status(32'h10);
        rd(1'b0, d); check("R7 overrun cleared", d, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule